// File: doc/BRIEF.md
# Four-Channel One-Shot Alarm Unit with Interrupt Control

This block holds a set of one-shot alarms that watch the low 32-bit word of a free-running timebase supplied from outside. Software loads a 32-bit target for an alarm through a simple register write port. That write also arms the alarm. On a later clock edge the timebase word can equal the target while the alarm is armed. On that edge the alarm disarms itself and latches a raw interrupt flag. Software can cancel an armed alarm early by writing ones to a shared armed-status register. A cancelled alarm raises no interrupt.

Interrupt handling uses four registers: raw, enable, force and masked status. Software clears raw flags by writing ones to them. Force bits inject interrupts for test. The masked status is the OR of raw and force, ANDed with enable, and it drives one interrupt line per alarm. A lock input from elsewhere in the chip freezes the alarm targets and the armed state. The interrupt registers stay writable while the lock is set. Reads are combinational and have no side effects.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset every target, armed bit, raw, enable and force bit is 0, and irq_o is 0.
- R2: A write to byte offset 0x10 + 4*i stores the 32-bit value as the target of alarm i and sets bit i of the armed register, which is read at offset 0x20.
- R3: If alarm i is armed and its target equals timebase_lo_i at a clock edge, then on that edge armed bit i clears and raw bit i sets. An unarmed alarm never sets its raw bit, so the same timebase value seen again has no effect.
- R4: Writing offset 0x20 disarms every alarm whose data bit is 1, and that alarm raises no interrupt. Data bits that are 0 leave their alarms unchanged.
- R5: Writing offset 0x3C clears each raw bit whose data bit is 1. If a fire and a clear reach the same raw bit in one cycle, the bit ends up set.
- R6: Offset 0x40 (enable) and offset 0x44 (force) are read/write. Offset 0x48 reads (raw | force) & enable.
- R7: irq_o[i] equals bit i of the value read at 0x48.
- R8: While lock_i is 1, writes to the target offsets and to 0x20 change nothing. The enable, force and raw registers can still be written.
- R9: If a target write and a match hit the same alarm in the same cycle, the alarm stays armed with the new target and its raw bit stays 0.
- R10: If a disarm write and a match hit the same alarm in the same cycle, the alarm ends up disarmed and its raw bit stays 0.
- R11: Alarms that match in the same cycle all fire together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timebase_lo_i | input | 32 | Low word of the running timebase |
| lock_i | input | 1 | Blocks writes to targets and to the armed register |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_o | output | 4 | Interrupt line for each alarm |

## Verification
On every cycle the assertions check four things. A fire drops its armed bit and sets its raw bit. A raw bit rises only after a fire. An armed bit rises only after an unlocked target write. An interrupt line is never high while its enable bit is clear. Only the directed scenarios can show the rest: that the stored target value comes back unchanged on a read, that a same-cycle write or disarm beats a match, that a set beats a clear on a raw bit, and that a matching timebase value seen again after firing does nothing. The masked read value and the interrupt lines are compared against values worked out in the bench.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam logic [7:0] OFS_TGT_BASE = 8'h10;
  localparam logic [7:0] OFS_ARMED    = 8'h20;
  localparam logic [7:0] OFS_RAW      = 8'h3C;
  localparam logic [7:0] OFS_EN       = 8'h40;
  localparam logic [7:0] OFS_FRC      = 8'h44;
  localparam logic [7:0] OFS_STAT     = 8'h48;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TGT,
    SEL_ARMED,
    SEL_RAW,
    SEL_EN,
    SEL_FRC,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/alarm_addr_dec.sv
module alarm_addr_dec
  import alarm_pkg::*;
#(
  parameter int unsigned NUM_ALARMS = 4,
  localparam int unsigned IDX_W = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1
) (
  input  logic [7:0]       addr_i,
  output reg_sel_e         sel_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [7:0] TGT_SPAN = 8'(4 * NUM_ALARMS);

  logic [7:0] off;
  assign off = addr_i - OFS_TGT_BASE;

  always_comb begin
    sel_o = SEL_NONE;
    idx_o = '0;
    if (addr_i >= OFS_TGT_BASE && off < TGT_SPAN && off[1:0] == 2'b00) begin
      sel_o = SEL_TGT;
      idx_o = off[IDX_W+1:2];
    end else begin
      unique case (addr_i)
        OFS_ARMED: sel_o = SEL_ARMED;
        OFS_RAW:   sel_o = SEL_RAW;
        OFS_EN:    sel_o = SEL_EN;
        OFS_FRC:   sel_o = SEL_FRC;
        OFS_STAT:  sel_o = SEL_STAT;
        default:   sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] timebase_lo_i,
  input  logic              tgt_we_i,
  input  logic              disarm_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] target_o,
  output logic              armed_o,
  output logic              fire_o
);
  logic [DATA_W-1:0] target_q;
  logic              armed_q;
  logic              hit;

  assign hit    = armed_q && (target_q == timebase_lo_i);
  // a write or disarm in the same cycle takes priority over a match
  assign fire_o = hit && !tgt_we_i && !disarm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
      armed_q  <= 1'b0;
    end else if (tgt_we_i) begin
      target_q <= wdata_i;
      armed_q  <= 1'b1;
    end else if (disarm_i || hit) begin
      armed_q  <= 1'b0;
    end
  end

  assign target_o = target_q;
  assign armed_o  = armed_q;
endmodule

// File: rtl/alarm_irq_regs.sv
module alarm_irq_regs #(
  parameter int unsigned NUM_ALARMS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_ALARMS-1:0] fire_i,
  input  logic                  raw_we_i,
  input  logic                  en_we_i,
  input  logic                  frc_we_i,
  input  logic [NUM_ALARMS-1:0] wdata_i,
  output logic [NUM_ALARMS-1:0] raw_o,
  output logic [NUM_ALARMS-1:0] en_o,
  output logic [NUM_ALARMS-1:0] frc_o,
  output logic [NUM_ALARMS-1:0] stat_o
);
  logic [NUM_ALARMS-1:0] raw_q, en_q, frc_q;
  logic [NUM_ALARMS-1:0] clr_mask;

  assign clr_mask = raw_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      en_q  <= '0;
      frc_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_mask) | fire_i;  // set beats clear
      if (en_we_i)  en_q  <= wdata_i;
      if (frc_we_i) frc_q <= wdata_i;
    end
  end

  assign raw_o  = raw_q;
  assign en_o   = en_q;
  assign frc_o  = frc_q;
  assign stat_o = (raw_q | frc_q) & en_q;
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_pkg::*;
#(
  parameter int unsigned NUM_ALARMS = 4,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DATA_W-1:0]     timebase_lo_i,
  input  logic                  lock_i,
  input  logic                  reg_we_i,
  input  logic [7:0]            reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [NUM_ALARMS-1:0] irq_o
);
  localparam int unsigned IDX_W = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1;

  reg_sel_e              sel;
  logic [IDX_W-1:0]      idx;
  logic [NUM_ALARMS-1:0] tgt_we, disarm, armed, fire;
  logic [NUM_ALARMS-1:0] raw, en, frc, stat;
  logic [DATA_W-1:0]     target [NUM_ALARMS];
  logic                  wr_ok;

  alarm_addr_dec #(.NUM_ALARMS(NUM_ALARMS)) u_dec (
    .addr_i (reg_addr_i),
    .sel_o  (sel),
    .idx_o  (idx)
  );

  assign wr_ok = reg_we_i && !lock_i;

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_ch
    assign tgt_we[i] = wr_ok && (sel == SEL_TGT) && (idx == IDX_W'(i));
    assign disarm[i] = wr_ok && (sel == SEL_ARMED) && reg_wdata_i[i];

    alarm_channel #(.DATA_W(DATA_W)) u_ch (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .timebase_lo_i (timebase_lo_i),
      .tgt_we_i      (tgt_we[i]),
      .disarm_i      (disarm[i]),
      .wdata_i       (reg_wdata_i),
      .target_o      (target[i]),
      .armed_o       (armed[i]),
      .fire_o        (fire[i])
    );
  end

  alarm_irq_regs #(.NUM_ALARMS(NUM_ALARMS)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .raw_we_i (reg_we_i && sel == SEL_RAW),
    .en_we_i  (reg_we_i && sel == SEL_EN),
    .frc_we_i (reg_we_i && sel == SEL_FRC),
    .wdata_i  (reg_wdata_i[NUM_ALARMS-1:0]),
    .raw_o    (raw),
    .en_o     (en),
    .frc_o    (frc),
    .stat_o   (stat)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_TGT:   reg_rdata_o = target[idx];
      SEL_ARMED: reg_rdata_o[NUM_ALARMS-1:0] = armed;
      SEL_RAW:   reg_rdata_o[NUM_ALARMS-1:0] = raw;
      SEL_EN:    reg_rdata_o[NUM_ALARMS-1:0] = en;
      SEL_FRC:   reg_rdata_o[NUM_ALARMS-1:0] = frc;
      SEL_STAT:  reg_rdata_o[NUM_ALARMS-1:0] = stat;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o = stat;
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk #(
  parameter int unsigned NUM_ALARMS = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  lock_i,
  input logic [NUM_ALARMS-1:0] armed,
  input logic [NUM_ALARMS-1:0] fire,
  input logic [NUM_ALARMS-1:0] tgt_we,
  input logic [NUM_ALARMS-1:0] raw,
  input logic [NUM_ALARMS-1:0] en,
  input logic [NUM_ALARMS-1:0] irq_o
);
  AST_FIRE_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fire) |=> ((armed & $past(fire)) == '0)); // R3
  AST_FIRE_SETS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fire) |=> ((raw & $past(fire)) == $past(fire))); // R3
  AST_RAW_NEEDS_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw & ~$past(raw) & ~$past(fire)) == '0)); // R5
  AST_ARM_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((armed & ~$past(armed) & ~$past(tgt_we)) == '0)); // R2
  AST_LOCK_NO_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> (tgt_we == '0)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~en) == '0)); // R6
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.NUM_ALARMS(NUM_ALARMS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .lock_i (lock_i),
  .armed  (armed),
  .fire   (fire),
  .tgt_we (tgt_we),
  .raw    (raw),
  .en     (en),
  .irq_o  (irq_o)
);

// File: tb/sim_alarm_irq_ctrl.sv
module sim_alarm_irq_ctrl;
  localparam logic [31:0] PARK = 32'hFFFF_0000;
  localparam logic [7:0]  A_ARM = 8'h20, A_RAW = 8'h3C, A_EN = 8'h40, A_FRC = 8'h44, A_STAT = 8'h48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tb_lo = PARK;
  logic        lock = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  alarm_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .timebase_lo_i(tb_lo), .lock_i(lock),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] tgt(int i);
    return 8'(8'h10 + 4 * i);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_at(logic [7:0] a, logic [31:0] d, logic [31:0] t);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; tb_lo = t;
    @(negedge clk);
    we = 1'b0; tb_lo = PARK;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_at(a, d, PARK);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic step_tb(logic [31:0] t);
    @(negedge clk);
    tb_lo = t;
    @(negedge clk);
    tb_lo = PARK;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_ARM, d);  chk("R1 armed", d, 0);
    rd(A_RAW, d);  chk("R1 raw", d, 0);
    rd(A_EN, d);   chk("R1 en", d, 0);
    rd(tgt(2), d); chk("R1 target", d, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_arm_fire;
    logic [31:0] d;
    wr(tgt(0), 32'd200);
    rd(tgt(0), d); chk("R2 target", d, 200);
    rd(A_ARM, d);  chk("R2 armed", d, 1);
    step_tb(32'd199);
    rd(A_RAW, d);  chk("R3 no early fire", d, 0);
    step_tb(32'd200);
    rd(A_ARM, d);  chk("R3 disarmed", d, 0);
    rd(A_RAW, d);  chk("R3 raw", d, 1);
    chk("R7 irq masked", 32'(irq), 0);
    rd(A_STAT, d); chk("R6 stat masked", d, 0);
  endtask

  task automatic t_irq_regs;
    logic [31:0] d;
    wr(A_EN, 32'h1);
    rd(A_STAT, d); chk("R6 stat", d, 1);
    chk("R7 irq on", 32'(irq), 1);
    wr(A_RAW, 32'h1);
    rd(A_RAW, d);  chk("R5 w1c", d, 0);
    chk("R7 irq off", 32'(irq), 0);
    step_tb(32'd200);
    rd(A_RAW, d);  chk("R3 one-shot", d, 0);
    wr(A_FRC, 32'h4);
    rd(A_STAT, d); chk("R6 force masked", d, 0);
    wr(A_EN, 32'h5);
    rd(A_STAT, d); chk("R6 force", d, 4);
    chk("R7 irq force", 32'(irq), 4);
    wr(A_FRC, 32'h0);
    chk("R7 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_disarm;
    logic [31:0] d;
    wr(tgt(1), 32'd500);
    wr(tgt(3), 32'd510);
    wr(A_ARM, 32'h2);
    rd(A_ARM, d);  chk("R4 selective disarm", d, 32'h8);
    step_tb(32'd500);
    rd(A_RAW, d);  chk("R4 no irq", d, 0);
    wr(A_ARM, 32'h8);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    wr(tgt(3), 32'd900);
    lock = 1'b1;
    wr(tgt(2), 32'd123);
    rd(A_ARM, d);  chk("R8 no arm", d, 32'h8);
    rd(tgt(2), d); chk("R8 target kept", d, 0);
    wr(A_ARM, 32'h8);
    rd(A_ARM, d);  chk("R8 no disarm", d, 32'h8);
    wr(A_EN, 32'h3);
    rd(A_EN, d);   chk("R8 en writable", d, 3);
    lock = 1'b0;
    wr(A_ARM, 32'h8);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_races;
    logic [31:0] d;
    wr(tgt(0), 32'd300);
    wr_at(tgt(0), 32'd400, 32'd300);
    rd(A_ARM, d);  chk("R9 still armed", d, 1);
    rd(tgt(0), d); chk("R9 new target", d, 400);
    rd(A_RAW, d);  chk("R9 no raw", d, 0);
    wr(A_ARM, 32'h1);
    wr(tgt(1), 32'd600);
    wr_at(A_ARM, 32'h2, 32'd600);
    rd(A_ARM, d);  chk("R10 disarmed", d, 0);
    rd(A_RAW, d);  chk("R10 no raw", d, 0);
  endtask

  task automatic t_multi;
    logic [31:0] d;
    wr(tgt(0), 32'd700);
    wr(tgt(2), 32'd700);
    wr(tgt(3), 32'd800);
    step_tb(32'd700);
    rd(A_RAW, d);  chk("R11 both fire", d, 32'h5);
    rd(A_ARM, d);  chk("R11 armed left", d, 32'h8);
    wr_at(A_RAW, 32'hD, 32'd800);
    rd(A_RAW, d);  chk("R5 set beats clear", d, 32'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_arm_fire();
    t_irq_regs();
    t_disarm();
    t_lock();
    t_races();
    t_multi();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule